// File: doc/BRIEF.md
# Debug Command Register Bank with Burst Buffer

This block sits in the system-clock domain between a serial debug port and a bus transaction engine. The serial side keeps presenting an 8-bit instruction and a data word on every cycle. The bank decodes the instruction. Operand opcodes copy the data word into the address, single-write data, burst-length and buffer-index registers, or into one entry of a small burst buffer. Operation opcodes launch a transaction by sending a one-cycle start pulse and an operation code to the bus engine.

An operation fires only on the cycle after its opcode newly appears on the instruction input. Holding the same opcode therefore launches exactly one transaction, and running it again needs a different instruction in between. A transaction in flight makes the bank busy until the engine returns a done strobe. Operation opcodes that arrive while the bank is busy are dropped.

The engine reads operands through a beat-index port. For each beat it gets the beat address, which starts at the stored base address and steps by the word size in bytes per beat, and the write data. The write data comes from the buffer for a burst write and from the single-data register otherwise. The engine writes read results back into the buffer. The serial side reads any buffer entry by setting the index register.

Top module: `jtag_cmd_bank`

## Requirements
- R1: After reset: `start_o` and `busy_o` are 0, every buffer entry, the address, the single data and the index are 0, and `beats_o` is 1.
- R2: While the instruction is 0x02, the address register takes `data_i`; while it is 0x03, the single-data register takes `data_i`. At beat index 0, `beat_addr_o` equals the address. Unless the last launched operation is a burst write, `beat_wdata_o` equals the single data.
- R3: Opcodes 0x01, 0x04, 0x09 and 0x0C raise `start_o` for exactly one cycle, on the cycle after the opcode appears. `op_o` then reads 0, 1, 2 and 3 respectively (single write, single read, burst write, burst read).
- R4: An operation opcode held for several cycles gives one pulse. The same opcode fires again only after some other instruction value has been presented between the two.
- R5: `busy_o` rises together with `start_o` and falls on the cycle after `done_i` is sampled high. An operation opcode that newly appears while busy never starts a transaction, including after busy clears.
- R6: Opcode 0x0A stores `data_i` modulo DEPTH as the buffer index. Opcode 0x0B writes `data_i` into the buffer entry at that index. `ret_data_o` always shows the entry at the index.
- R7: During a burst write, `beat_wdata_o` is the buffer entry at `beat_idx_i`. For every operation, `beat_addr_o` is the address plus `beat_idx_i` times DATA_W/8.
- R8: Opcode 0x08 stores the burst length from `data_i`: 0 becomes 1, and values above DEPTH become DEPTH. `beats_o` shows that length for burst operations and 1 for single operations.
- R9: `rd_we_i` writes `rd_data_i` into the buffer at `rd_idx_i`. It takes priority over opcode 0x0B when both address the same entry in the same cycle.
- R10: Any other instruction value changes no register: address, single data, index, burst length and buffer all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 8 | Instruction presented by the serial side |
| data_i | input | DATA_W | Data word presented by the serial side |
| start_o | output | 1 | One-cycle transaction launch |
| op_o | output | 2 | Kind of the last launched operation |
| busy_o | output | 1 | Transaction in flight |
| beats_o | output | IDX_W+1 | Number of beats of the current operation |
| done_i | input | 1 | Transaction complete strobe from the bus engine |
| beat_idx_i | input | IDX_W | Beat the bus engine is working on |
| beat_addr_o | output | ADDR_W | Address for that beat |
| beat_wdata_o | output | DATA_W | Write data for that beat |
| rd_we_i | input | 1 | Read result write enable |
| rd_idx_i | input | IDX_W | Buffer entry for the read result |
| rd_data_i | input | DATA_W | Read result word |
| ret_data_o | output | DATA_W | Buffer entry at the index, returned to the serial side |

## Verification
The bench builds the bank with DEPTH of 8 and 32-bit data and address, which puts index wrap and length clamping within a few operand writes. An index of 9 lands on entry 1, and lengths of 12 and 16 clamp to 8, exercising the modulo and saturation paths. A 32-bit word gives a 4-byte beat stride, so the address check at beat 3 confirms the scaling as well as the offset.

// File: rtl/jtag_cmd_bank.sv
module jtag_cmd_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        instr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output logic [1:0]        op_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  beats_o,
  input  logic              done_i,
  input  logic [IDX_W-1:0]  beat_idx_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [DATA_W-1:0] beat_wdata_o,
  input  logic              rd_we_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] ret_data_o
);
  localparam logic [7:0] OP_WR   = 8'h01;
  localparam logic [7:0] OP_ADDR = 8'h02;
  localparam logic [7:0] OP_DATA = 8'h03;
  localparam logic [7:0] OP_RD   = 8'h04;
  localparam logic [7:0] OP_LEN  = 8'h08;
  localparam logic [7:0] OP_BWR  = 8'h09;
  localparam logic [7:0] OP_IDX  = 8'h0A;
  localparam logic [7:0] OP_BUF  = 8'h0B;
  localparam logic [7:0] OP_BRD  = 8'h0C;
  localparam int STEP = DATA_W / 8;

  logic [7:0]        prev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] sdata_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  len_q;
  logic [1:0]        op_q;
  logic              start_q, busy_q;
  logic [DATA_W-1:0] buf_q [DEPTH];

  logic       is_op;
  logic [1:0] op_d;
  logic       trig;
  logic [CNT_W-1:0] len_d;

  always_comb begin
    is_op = 1'b1;
    op_d  = 2'd0;
    case (instr_i)
      OP_WR:   op_d = 2'd0;
      OP_RD:   op_d = 2'd1;
      OP_BWR:  op_d = 2'd2;
      OP_BRD:  op_d = 2'd3;
      default: is_op = 1'b0;
    endcase
  end

  assign trig = is_op && (instr_i != prev_q) && !busy_q;

  always_comb begin
    if (data_i == '0)
      len_d = CNT_W'(1);
    else if (data_i > DATA_W'(DEPTH))
      len_d = CNT_W'(DEPTH);
    else
      len_d = data_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      addr_q  <= '0;
      sdata_q <= '0;
      idx_q   <= '0;
      len_q   <= CNT_W'(1);
      op_q    <= '0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      prev_q  <= instr_i;
      start_q <= trig;
      busy_q  <= trig | (busy_q & ~done_i);
      if (trig) op_q <= op_d;
      if (instr_i == OP_ADDR) addr_q  <= data_i[ADDR_W-1:0];
      if (instr_i == OP_DATA) sdata_q <= data_i;
      if (instr_i == OP_IDX)  idx_q   <= data_i[IDX_W-1:0];
      if (instr_i == OP_LEN)  len_q   <= len_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        buf_q[g] <= '0;
      else if (rd_we_i && rd_idx_i == IDX_W'(g))
        buf_q[g] <= rd_data_i;
      else if (instr_i == OP_BUF && idx_q == IDX_W'(g))
        buf_q[g] <= data_i;
    end
  end

  assign start_o      = start_q;
  assign busy_o       = busy_q;
  assign op_o         = op_q;
  assign beats_o      = op_q[1] ? len_q : CNT_W'(1);
  assign beat_addr_o  = addr_q + ADDR_W'(beat_idx_i) * ADDR_W'(STEP);
  assign beat_wdata_o = (op_q == 2'd2) ? buf_q[beat_idx_i] : sdata_q;
  assign ret_data_o   = buf_q[idx_q];
endmodule

module jtag_cmd_bank_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_o,
  input logic             busy_o,
  input logic             done_i,
  input logic [CNT_W-1:0] beats_o
);
  p_pulse_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  p_busy_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);
  p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_o) |=> !start_o);
  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i) |=> !busy_o);
  p_beats_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beats_o != '0) && (beats_o <= CNT_W'(DEPTH)));
endmodule

bind jtag_cmd_bank jtag_cmd_bank_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_o(start_o), .busy_o(busy_o),
  .done_i(done_i), .beats_o(beats_o)
);

// File: tb/test_jtag_cmd_bank.sv
module test_jtag_cmd_bank;
  localparam int DW = 32, AW = 32, DEPTH = 8, IW = 3, CW = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] instr_i = 0;
  logic [DW-1:0] data_i = 0;
  logic done_i = 1, rd_we_i = 0;
  logic [IW-1:0] beat_idx_i = 0, rd_idx_i = 0;
  logic [DW-1:0] rd_data_i = 0;
  logic start_o, busy_o;
  logic [1:0] op_o;
  logic [CW-1:0] beats_o;
  logic [AW-1:0] beat_addr_o;
  logic [DW-1:0] beat_wdata_o, ret_data_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  jtag_cmd_bank #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEPTH)) i_jtag_cmd_bank (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .data_i(data_i),
    .start_o(start_o), .op_o(op_o), .busy_o(busy_o), .beats_o(beats_o),
    .done_i(done_i), .beat_idx_i(beat_idx_i), .beat_addr_o(beat_addr_o),
    .beat_wdata_o(beat_wdata_o), .rd_we_i(rd_we_i), .rd_idx_i(rd_idx_i),
    .rd_data_i(rd_data_i), .ret_data_o(ret_data_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(logic [7:0] ins, logic [DW-1:0] d);
    instr_i = ins;
    data_i  = d;
    @(negedge clk);
  endtask

  // instr, data, done, expected start, expected op
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {8'h00, 32'h0, 1'b1, 1'b0, 2'd0},
    {8'h01, 32'h0, 1'b1, 1'b1, 2'd0},
    {8'h01, 32'h0, 1'b1, 1'b0, 2'd0},
    {8'h04, 32'h0, 1'b1, 1'b1, 2'd1},
    {8'h04, 32'h0, 1'b1, 1'b0, 2'd1},
    {8'h07, 32'h0, 1'b1, 1'b0, 2'd1},
    {8'h04, 32'h0, 1'b1, 1'b1, 2'd1},
    {8'h00, 32'h0, 1'b1, 1'b0, 2'd1},
    {8'h09, 32'h0, 1'b1, 1'b1, 2'd2},
    {8'h00, 32'h0, 1'b1, 1'b0, 2'd2},
    {8'h0C, 32'h0, 1'b1, 1'b1, 2'd3},
    {8'h00, 32'h0, 1'b1, 1'b0, 2'd3}
  };

  initial begin
    #1600000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 start", start_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 ret", ret_data_o, 0);
    check("R1 beats", beats_o, 1);
    check("R1 addr", beat_addr_o, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      done_i = VEC[i][3];
      step(VEC[i][43:36], VEC[i][35:4]);
      check("R3/R4 start", start_o, VEC[i][2]);
      if (VEC[i][2]) check("R3 op", op_o, VEC[i][1:0]);
    end
    @(negedge clk);
    check("R3 pulse width", start_o, 0);

    // R5 busy suppression
    done_i = 0;
    step(8'h01, 0);
    check("R5 start", start_o, 1);
    check("R5 busy", busy_o, 1);
    step(8'h00, 0);
    step(8'h04, 0);
    check("R5 suppressed", start_o, 0);
    check("R5 still busy", busy_o, 1);
    done_i = 1;
    @(negedge clk);
    check("R5 cleared", busy_o, 0);
    @(negedge clk);
    check("R5 stale op dropped", start_o, 0);
    step(8'h00, 0);

    // R2 operands
    step(8'h02, 32'h1000);
    step(8'h03, 32'hCAFE);
    step(8'h00, 32'hDEAD);
    beat_idx_i = 0;
    #1;
    check("R2 addr", beat_addr_o, 32'h1000);
    check("R2 wdata", beat_wdata_o, 32'hCAFE);
    beat_idx_i = 3;
    #1;
    check("R7 addr stride", beat_addr_o, 32'h100C);

    // R6 index wrap and buffer write
    step(8'h0A, 9);
    step(8'h0B, 32'hAA11);
    step(8'h00, 0);
    check("R6 wrap write", ret_data_o, 32'hAA11);
    step(8'h0A, 2);
    check("R6 other entry", ret_data_o, 0);
    step(8'h0A, 1);
    check("R6 readback", ret_data_o, 32'hAA11);

    // R10 unknown opcode
    step(8'h05, 32'hFFFF);
    step(8'h7F, 32'h5);
    step(8'h00, 0);
    beat_idx_i = 0;
    #1;
    check("R10 addr kept", beat_addr_o, 32'h1000);
    check("R10 data kept", beat_wdata_o, 32'hCAFE);
    check("R10 index/buf kept", ret_data_o, 32'hAA11);
    check("R10 no start", start_o, 0);

    // R8 burst length
    step(8'h08, 0);
    step(8'h00, 0);
    step(8'h09, 0);
    check("R8 zero len", beats_o, 1);
    step(8'h08, 5);
    step(8'h00, 0);
    check("R8 len 5", beats_o, 5);
    step(8'h08, 12);
    step(8'h00, 0);
    check("R8 clamp 12", beats_o, DEPTH);
    step(8'h08, 16);
    step(8'h00, 0);
    check("R8 clamp 16", beats_o, DEPTH);

    // R7 burst write data from buffer
    step(8'h0A, 3);
    step(8'h0B, 32'h3333);
    step(8'h00, 0);
    beat_idx_i = 3;
    #1;
    check("R7 burst wdata", beat_wdata_o, 32'h3333);
    check("R7 burst addr", beat_addr_o, 32'h100C);
    beat_idx_i = 1;
    #1;
    check("R7 burst wdata b1", beat_wdata_o, 32'hAA11);

    step(8'h01, 0);
    check("R8 single beats", beats_o, 1);
    check("R2 single wdata", beat_wdata_o, 32'hCAFE);
    step(8'h00, 0);

    // R9 read results
    rd_we_i = 1; rd_idx_i = 4; rd_data_i = 32'h4444;
    step(8'h00, 0);
    rd_we_i = 0;
    step(8'h0A, 4);
    check("R9 read store", ret_data_o, 32'h4444);
    rd_we_i = 1; rd_data_i = 32'h6666;
    step(8'h0B, 32'h5555);
    rd_we_i = 0;
    step(8'h00, 0);
    check("R9 priority", ret_data_o, 32'h6666);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule